// File: doc/BRIEF.md
# Video RAM bank mapping controller

This block places nine physical video-memory banks of unequal size into one CPU-visible address window. Each bank has its own 8-bit control byte. The byte enables the bank, picks a mapping code and picks an offset. From the registered control bytes and the CPU address, the block decodes a nine-bit bank-select vector at a granularity of 16 KiB slots. It also produces the address inside each bank.

A CPU write goes to every selected bank at once. A CPU read returns the bitwise OR of the data from all selected banks. Overlapping placements are therefore legal and behave as a wired-OR, not as an error. The bank memories, the display fetch paths and the wait-state timing sit outside this block.

Top module: `vbm_bank_map`

## Requirements
- R1: After reset all control bytes are zero, so no bank is selected at any address until a control byte with its enable bit set is written.
- R2: In a control byte, bit 7 enables the bank, bits 2:0 hold the mapping code and bits 4:3 hold the offset select. A bank whose bit 7 is clear is selected nowhere. A control write with a bank index from 9 to 15 changes no bank.
- R3: A control write takes effect from the clock edge that captures it. In the cycle the write is presented, the selects still follow the old byte.
- R4: The slot number is CPU address bits 23:14. Bits 23:21 give the window and bits 19:14 give the position (0 to 63) inside the window. Address bit 20 has no effect on selection.
- R5: Code 0 maps to window 4 with a repeat of 64 slots. The start slots are 0, 8, 16, 24, 32, 36, 37, 38 and 40 for banks 0 to 8.
- R6: Code 1 maps banks 0 to 6 to window 0 with a repeat of 32. The start is offset select times 8 for banks 0 to 3. For bank 5 the start is 0, 1, 4 or 5. For banks 4 and 6 the start is 0.
- R7: Code 2 maps banks 0, 1, 4, 5, 6 and 7 to window 2 with a repeat of 16. For banks 0 and 1, offset selects 0 and 1 start at 0 and 8, while selects 2 and 3 leave the bank unmapped. Bank 5 starts at 0, 1, 4 or 5. The other banks start at 0.
- R8: Fixed mappings: code 4 puts bank 2 in window 1 and bank 3 in window 3, each with a repeat of 8. Code 1 puts bank 7 in window 1 with a repeat of 4, and bank 8 in window 1 from slot 2 with a repeat of 4. Code 2 puts bank 8 in window 3 with a repeat of 1.
- R9: A mapped bank covers as many consecutive slots as its size divided by 16 KiB, starting at its start slot. It repeats every repeat-size slots up to position 63.
- R10: Any code and bank pair not listed in R5 to R8 leaves the bank unmapped.
- R11: Each bank's address output equals the CPU address masked to the bank size. Banks 0 to 3 are 128 KiB, bank 4 is 64 KiB, bank 7 is 32 KiB, and banks 5, 6 and 8 are 16 KiB.
- R12: Each bank's write strobe is the CPU write strobe ANDed with that bank's select. The write data goes to all banks unchanged.
- R13: Read data is the bitwise OR of the data inputs of all selected banks, and zero when no bank is selected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Control byte write strobe |
| cfg_sel_i | input | 4 | Bank index of the control write |
| cfg_byte_i | input | 8 | Control byte value |
| cpu_addr_i | input | 24 | CPU byte address |
| cpu_we_i | input | 1 | CPU write strobe |
| cpu_wdata_i | input | DATA_W | CPU write data |
| cpu_rdata_o | output | DATA_W | ORed read data |
| bank_sel_o | output | 9 | Per-bank select vector |
| bank_we_o | output | 9 | Per-bank write strobe |
| bank_addr_o | output | 153 | Nine 17-bit in-bank addresses, bank 0 lowest |
| bank_wdata_o | output | DATA_W | Write data to all banks |
| bank_rdata_i | input | 9*DATA_W | Read data from the nine banks, bank 0 lowest |

## Verification
The assertions assume that every input holds a defined value from reset onward. They also assume that control writes and CPU accesses arrive on the same clock, with no extra handshake. Bank read data is treated as arbitrary, so the OR and zero-data properties hold whatever the banks return. The bench drives all inputs at the falling edge with fully defined random or swept values. It uses bank indices across the full 4-bit range, including the unused ones, so the stimulus stays inside these assumptions while still reaching every code and offset select.

// File: rtl/vbm_pkg.sv
package vbm_pkg;
  localparam int NUM_BANKS  = 9;
  localparam int SLOT_SHIFT = 14;
  localparam int SLOT_BITS  = 10;
  localparam int ADDR_W     = SLOT_SHIFT + SLOT_BITS;
  localparam int BADDR_W    = 17;
  localparam int IDX_W      = 4;

  typedef struct packed {
    logic       valid;
    logic [2:0] win;
    logic [7:0] start;
    logic [6:0] rep;
  } map_t;

  function automatic int bank_slots(input int b);
    if (b < 4) return 8;
    if (b == 4) return 4;
    if (b == 7) return 2;
    return 1;
  endfunction

  function automatic int bank_abits(input int b);
    return SLOT_SHIFT + $clog2(bank_slots(b));
  endfunction

  function automatic logic [7:0] direct_base(input int b);
    case (b)
      0: return 8'd0;
      1: return 8'd8;
      2: return 8'd16;
      3: return 8'd24;
      4: return 8'd32;
      5: return 8'd36;
      6: return 8'd37;
      7: return 8'd38;
      default: return 8'd40;
    endcase
  endfunction

  // obj=1 pushes large banks past the window for selects 2,3
  function automatic logic [7:0] grp_ofs(input int b, input logic [1:0] osel, input logic obj);
    if (b < 4) return (obj && osel[1]) ? 8'd128 : {3'b0, osel, 3'b0};
    if (b == 5) return {5'b0, osel[1], 1'b0, osel[0]};
    return 8'd0;
  endfunction

  function automatic map_t bank_map(input int b, input logic [2:0] code, input logic [1:0] osel);
    map_t m;
    m = '0;
    case (code)
      3'd0: begin
        m.valid = 1'b1; m.win = 3'd4; m.rep = 7'd64; m.start = direct_base(b);
      end
      3'd1: begin
        m.valid = 1'b1;
        if (b >= 7) begin
          m.win = 3'd1; m.rep = 7'd4; m.start = (b == 8) ? 8'd2 : 8'd0;
        end else begin
          m.win = 3'd0; m.rep = 7'd32; m.start = grp_ofs(b, osel, 1'b0);
        end
      end
      3'd2: begin
        if (b == 8) begin
          m.valid = 1'b1; m.win = 3'd3; m.rep = 7'd1;
        end else if (b != 2 && b != 3) begin
          m.valid = 1'b1; m.win = 3'd2; m.rep = 7'd16; m.start = grp_ofs(b, osel, 1'b1);
        end
      end
      3'd4: begin
        if (b == 2 || b == 3) begin
          m.valid = 1'b1; m.win = (b == 2) ? 3'd1 : 3'd3; m.rep = 7'd8;
        end
      end
      default: m = '0;
    endcase
    return m;
  endfunction
endpackage

// File: rtl/vbm_cfg_regs.sv
module vbm_cfg_regs
  import vbm_pkg::*;
#(
  parameter int NB = NUM_BANKS
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 we_i,
  input  logic [IDX_W-1:0]     sel_i,
  input  logic [7:0]           byte_i,
  output logic [NB-1:0][7:0]   cfg_o
);
  for (genvar b = 0; b < NB; b++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                               cfg_o[b] <= 8'h00;
      else if (we_i && sel_i == IDX_W'(b))       cfg_o[b] <= byte_i;
    end
  end
endmodule

// File: rtl/vbm_bank_decode.sv
module vbm_bank_decode
  import vbm_pkg::*;
#(
  parameter int BANK = 0
) (
  input  logic [7:0]         cfg_i,
  input  logic [ADDR_W-1:0]  addr_i,
  output logic               hit_o,
  output logic [BADDR_W-1:0] baddr_o
);
  localparam int AB = bank_abits(BANK);
  localparam logic [7:0] NSL = 8'(bank_slots(BANK));

  logic [SLOT_BITS-1:0] slot;
  logic [7:0] pos, diff, wrap;
  map_t m;
  logic unused_bits;

  assign slot = addr_i[SLOT_SHIFT +: SLOT_BITS];
  assign pos  = {2'b00, slot[5:0]};
  assign unused_bits = ^{slot[6], cfg_i[6:5]};

  always_comb begin
    m     = bank_map(BANK, cfg_i[2:0], cfg_i[4:3]);
    diff  = pos - m.start;
    wrap  = diff & {1'b0, m.rep - 7'd1};
    hit_o = cfg_i[7] && m.valid && (slot[9:7] == m.win) && (pos >= m.start) && (wrap < NSL);
  end

  assign baddr_o = BADDR_W'(addr_i[AB-1:0]);
endmodule

// File: rtl/vbm_data_path.sv
module vbm_data_path #(
  parameter int NB     = 9,
  parameter int DATA_W = 32
) (
  input  logic [NB-1:0]             hit_i,
  input  logic                      we_i,
  input  logic [NB-1:0][DATA_W-1:0] rdata_i,
  output logic [NB-1:0]             we_o,
  output logic [DATA_W-1:0]         rdata_o
);
  assign we_o = hit_i & {NB{we_i}};

  always_comb begin
    rdata_o = '0;
    for (int b = 0; b < NB; b++)
      if (hit_i[b]) rdata_o |= rdata_i[b];
  end
endmodule

// File: rtl/vbm_bank_map.sv
module vbm_bank_map
  import vbm_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          cfg_we_i,
  input  logic [IDX_W-1:0]              cfg_sel_i,
  input  logic [7:0]                    cfg_byte_i,
  input  logic [ADDR_W-1:0]             cpu_addr_i,
  input  logic                          cpu_we_i,
  input  logic [DATA_W-1:0]             cpu_wdata_i,
  output logic [DATA_W-1:0]             cpu_rdata_o,
  output logic [NUM_BANKS-1:0]          bank_sel_o,
  output logic [NUM_BANKS-1:0]          bank_we_o,
  output logic [NUM_BANKS*BADDR_W-1:0]  bank_addr_o,
  output logic [DATA_W-1:0]             bank_wdata_o,
  input  logic [NUM_BANKS*DATA_W-1:0]   bank_rdata_i
);
  logic [NUM_BANKS-1:0][7:0] cfg;
  logic [NUM_BANKS-1:0]      hit;

  vbm_cfg_regs #(.NB(NUM_BANKS)) u_cfg (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (cfg_we_i),
    .sel_i  (cfg_sel_i),
    .byte_i (cfg_byte_i),
    .cfg_o  (cfg)
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    vbm_bank_decode #(.BANK(b)) u_dec (
      .cfg_i   (cfg[b]),
      .addr_i  (cpu_addr_i),
      .hit_o   (hit[b]),
      .baddr_o (bank_addr_o[b*BADDR_W +: BADDR_W])
    );
  end

  vbm_data_path #(.NB(NUM_BANKS), .DATA_W(DATA_W)) u_dp (
    .hit_i   (hit),
    .we_i    (cpu_we_i),
    .rdata_i (bank_rdata_i),
    .we_o    (bank_we_o),
    .rdata_o (cpu_rdata_o)
  );

  assign bank_sel_o   = hit;
  assign bank_wdata_o = cpu_wdata_i;
endmodule

// File: rtl/vbm_checker.sv
module vbm_checker
  import vbm_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input logic                         clk_i,
  input logic                         rst_ni,
  input logic                         cfg_we_i,
  input logic [IDX_W-1:0]             cfg_sel_i,
  input logic [7:0]                   cfg_byte_i,
  input logic [ADDR_W-1:0]            cpu_addr_i,
  input logic                         cpu_we_i,
  input logic [DATA_W-1:0]            cpu_rdata_o,
  input logic [NUM_BANKS-1:0]         bank_sel_o,
  input logic [NUM_BANKS-1:0]         bank_we_o,
  input logic [NUM_BANKS*BADDR_W-1:0] bank_addr_o
);
  logic cfg_seen;
  logic unused_chk;
  assign unused_chk = ^{cpu_addr_i[ADDR_W-1:SLOT_SHIFT], cfg_byte_i[6:0]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cfg_seen <= 1'b0;
    else if (cfg_we_i && cfg_byte_i[7] && cfg_sel_i < IDX_W'(NUM_BANKS)) cfg_seen <= 1'b1;
  end

  p_reset_unmapped_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cfg_seen |-> bank_sel_o == '0);

  p_disable_clears_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_we_i && !cfg_byte_i[7] && cfg_sel_i < IDX_W'(NUM_BANKS)) |=> !bank_sel_o[$past(cfg_sel_i)]);

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_addr
    logic unused_hi;
    assign unused_hi = ^bank_addr_o[b*BADDR_W+SLOT_SHIFT +: BADDR_W-SLOT_SHIFT];
    p_low_addr_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
      bank_addr_o[b*BADDR_W +: SLOT_SHIFT] == cpu_addr_i[SLOT_SHIFT-1:0]);
  end

  p_we_subset_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bank_we_o & ~bank_sel_o) == '0);

  p_no_write_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cpu_we_i |-> bank_we_o == '0);

  p_nohit_zero_r13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bank_sel_o == '0 |-> cpu_rdata_o == '0);
endmodule

bind vbm_bank_map vbm_checker #(.DATA_W(DATA_W)) u_vbm_chk (.*);

// File: tb/tb_vbm_bank_map.sv
module tb_vbm_bank_map;
  localparam int NB = 9;
  localparam int DW = 32;
  localparam int BAW = 17;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic cfg_we = 1'b0;
  logic [3:0] cfg_sel = '0;
  logic [7:0] cfg_byte = '0;
  logic [23:0] addr = '0;
  logic cpu_we = 1'b0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rdata;
  logic [NB-1:0] sel, bwe;
  logic [NB*BAW-1:0] baddr;
  logic [DW-1:0] bwdata;
  logic [NB-1:0][DW-1:0] brdata = '0;

  logic [7:0] mcfg [NB];
  int n_checks = 0, n_fail = 0;
  bit done = 0;

  always #2 clk_i = ~clk_i;

  vbm_bank_map #(.DATA_W(DW)) dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .cfg_we_i(cfg_we), .cfg_sel_i(cfg_sel),
    .cfg_byte_i(cfg_byte), .cpu_addr_i(addr), .cpu_we_i(cpu_we), .cpu_wdata_i(wdata),
    .cpu_rdata_o(rdata), .bank_sel_o(sel), .bank_we_o(bwe), .bank_addr_o(baddr),
    .bank_wdata_o(bwdata), .bank_rdata_i(brdata)
  );

  function automatic bit ref_hit(int b, logic [7:0] c, logic [9:0] slot);
    int win = 0, base = 0, rep = 64, n;
    int ofs[4] = '{0, 0, 0, 0};
    bit ok = 1;
    if (!c[7]) return 0;
    n = (b < 4) ? 8 : (b == 4) ? 4 : (b == 7) ? 2 : 1;
    case (c[2:0])
      3'd0: begin
        win = 4;
        base = (b < 4) ? b * 8 : (b == 8) ? 40 : 32 + (b == 4 ? 0 : b - 1);
      end
      3'd1: begin
        if (b >= 7) begin win = 1; rep = 4; base = (b == 8) ? 2 : 0; end
        else begin
          win = 0; rep = 32;
          if (b < 4) ofs = '{0, 8, 16, 24};
          if (b == 5) ofs = '{0, 1, 4, 5};
        end
      end
      3'd2: begin
        if (b == 2 || b == 3) ok = 0;
        else if (b == 8) begin win = 3; rep = 1; end
        else begin
          win = 2; rep = 16;
          if (b < 2) ofs = '{0, 8, 128, 128};
          if (b == 5) ofs = '{0, 1, 4, 5};
        end
      end
      3'd4: begin
        if (b == 2) begin win = 1; rep = 8; end
        else if (b == 3) begin win = 3; rep = 8; end
        else ok = 0;
      end
      default: ok = 0;
    endcase
    if (!ok || int'(slot[9:7]) != win) return 0;
    for (int j = base + ofs[c[4:3]]; j < 64; j += rep)
      for (int i = 0; i < n; i++)
        if (i + j == int'(slot[5:0])) return 1;
    return 0;
  endfunction

  task automatic chk(string tag, logic [255:0] act, logic [255:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h (addr %06h)", tag, act, exp, addr);
    end
  endtask

  task automatic check_all(string tag);
    logic [NB-1:0] es;
    logic [DW-1:0] er = '0;
    logic [NB*BAW-1:0] ea;
    for (int b = 0; b < NB; b++) begin
      int sz = (b < 4) ? 131072 : (b == 4) ? 65536 : (b == 7) ? 32768 : 16384;
      es[b] = ref_hit(b, mcfg[b], addr[23:14]);
      if (es[b]) er |= brdata[b];
      ea[b*BAW +: BAW] = BAW'(int'(addr) % sz);
    end
    chk(tag, 256'(sel), 256'(es));
    chk("R12 write strobes", 256'(bwe), 256'(es & {NB{cpu_we}}));
    chk("R12 write data", 256'(bwdata), 256'(wdata));
    chk("R13 read OR", 256'(rdata), 256'(er));
    chk("R11 bank address", 256'(baddr), 256'(ea));
  endtask

  task automatic tick(string tag);
    bit pw = cfg_we;
    int ps = cfg_sel;
    logic [7:0] pb = cfg_byte;
    @(negedge clk_i);
    if (pw && ps < NB) mcfg[ps] = pb;
    cfg_we = 1'b0;
    check_all(tag);
  endtask

  task automatic put_cfg(int idx, logic [7:0] v);
    cfg_we = 1'b1; cfg_sel = 4'(idx); cfg_byte = v;
    tick("R3 config cycle");
  endtask

  task automatic rand_access(logic [9:0] slot);
    addr = {slot, 14'($urandom)};
    cpu_we = 1'($urandom);
    wdata = $urandom;
    for (int b = 0; b < NB; b++) brdata[b] = $urandom;
  endtask

  task automatic sweep(string tag);
    for (int s = 0; s < 1024; s++) begin
      rand_access(10'(s));
      tick(tag);
    end
  endtask

  task automatic clear_all();
    for (int b = 0; b < NB; b++) put_cfg(b, 8'h00);
  endtask

  initial begin
    for (int b = 0; b < NB; b++) mcfg[b] = 8'h00;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    // R1: reset state, nothing mapped anywhere
    sweep("R1 reset selects");

    // R2: out-of-range index writes ignored
    for (int k = 9; k < 16; k++) put_cfg(k, 8'h80);
    sweep("R2 unused index ignored");

    // R3: write has no effect in its own cycle, effect after the edge
    addr = {10'h200, 14'h0};
    cfg_we = 1'b1; cfg_sel = 4'd0; cfg_byte = 8'h80;
    #1;
    chk("R3 before edge", 256'(sel[0]), 256'(0));
    tick("R3 after edge");
    chk("R3 after edge bank0", 256'(sel[0]), 256'(1));

    // R5: direct window for all banks
    for (int b = 0; b < NB; b++) put_cfg(b, 8'h80);
    sweep("R5 direct window");
    // R2: disabled bank with valid code
    put_cfg(4, 8'h00);
    put_cfg(7, 8'h7F & 8'h00);
    sweep("R2 disabled bank");

    // R6: primary background group with offsets, overlaps OR
    clear_all();
    put_cfg(0, 8'h81); put_cfg(1, 8'h89); put_cfg(2, 8'h91); put_cfg(3, 8'h99);
    put_cfg(4, 8'h81); put_cfg(5, 8'h91); put_cfg(6, 8'h99);
    sweep("R6 code1 background");
    put_cfg(5, 8'h99); put_cfg(0, 8'h99);
    sweep("R6 code1 offset 3");

    // R7: primary object group, large banks pushed out by high selects
    clear_all();
    put_cfg(0, 8'h8A); put_cfg(1, 8'h92); put_cfg(4, 8'h82); put_cfg(5, 8'h8A);
    put_cfg(6, 8'h82); put_cfg(7, 8'h82);
    sweep("R7 code2 object");
    put_cfg(0, 8'h9A); put_cfg(1, 8'h82); put_cfg(5, 8'h9A);
    sweep("R7 code2 offset 3");

    // R8: fixed secondary mappings
    clear_all();
    put_cfg(2, 8'h84); put_cfg(3, 8'h84); put_cfg(7, 8'h81); put_cfg(8, 8'h81);
    sweep("R8 fixed secondary");
    put_cfg(8, 8'h82);
    sweep("R8 bank8 every slot");

    // R10: undefined code/bank pairs unmapped
    clear_all();
    put_cfg(0, 8'h84); put_cfg(2, 8'h82); put_cfg(3, 8'h82); put_cfg(4, 8'h83);
    put_cfg(5, 8'h85); put_cfg(6, 8'h86); put_cfg(7, 8'h87); put_cfg(8, 8'h84);
    sweep("R10 undefined codes");

    // R4 R9: random configs and addresses, bit 20 varies freely
    for (int i = 0; i < 4000; i++) begin
      if ($urandom_range(3) == 0) begin
        cfg_we = 1'b1;
        cfg_sel = 4'($urandom_range(15));
        cfg_byte = {($urandom_range(4) != 0), 2'($urandom), 2'($urandom), 3'($urandom_range(4))};
      end
      rand_access(10'($urandom));
      tick("R4 R9 random mapping");
    end

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    #(4 * 150000);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end
endmodule